// File: doc/BRIEF.md
# Field Rate 50/60 Hz Identifier

This block decides whether an incoming television vertical sync train belongs to a 50 Hz or a 60 Hz standard. It counts free-running reference clocks between successive rising edges of the sync pulse. Each measured interval is sorted into one of three classes: 50 Hz, 60 Hz or out of range. A single registered flag reports the decision. It is high for 60 Hz and low for 50 Hz.

The flag is deliberately slow to move. Any field whose rate is outside the 45 to 65 Hz window leaves the flag as it is. The flag flips only after the opposite standard has been seen on three fields in a row. A field that is out of range, or that agrees with the current flag, restarts that run. The band edges are given in hertz and converted to clock counts from the reference clock frequency at elaboration time. A one-cycle strobe with the class of each measured field is brought out for debug.

Top module: `field_rate_ident`

## Requirements
- R1: A field period between CLK_HZ/65 and CLK_HZ/55 clocks, both inclusive, is classed as 60 Hz. Three such fields in a row, seen while the flag is low, drive `rate_60_o` high.
- R2: A field period above CLK_HZ/55 and at most CLK_HZ/45 clocks is classed as 50 Hz. Three such fields in a row, seen while the flag is high, drive `rate_60_o` low.
- R3: A field period below CLK_HZ/65 or above CLK_HZ/45 clocks leaves `rate_60_o` unchanged. It also clears the run of opposite-rate fields.
- R4: One or two opposite-rate fields in a row never change `rate_60_o`.
- R5: The split between the two standards is at 55 Hz. A 54 Hz train is taken as 50 Hz and a 56 Hz train as 60 Hz.
- R6: While `rst_n` is low, and on the first cycle after it, `rate_60_o` is low and the run count is zero.
- R7: The first rising edge of `vsync_i` after reset only starts a measurement and produces no `field_valid_o` strobe.
- R8: The period counter saturates just beyond CLK_HZ/45. An absent sync followed by a late edge is therefore classed as out of range, and the flag holds.
- R9: `field_valid_o` pulses for one cycle per measured field. During that pulse `field_class_o` gives 2'b00 for out of range, 2'b01 for 50 Hz and 2'b10 for 60 Hz.
- R10: A field that matches the current flag clears the run of opposite-rate fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| vsync_i | input | 1 | Vertical sync pulse, asynchronous, active high |
| rate_60_o | output | 1 | Decision flag: 1 = 60 Hz, 0 = 50 Hz |
| field_valid_o | output | 1 | One-cycle strobe per measured field |
| field_class_o | output | 2 | Class of the field under the strobe |

## Verification
The bench goes after runs of opposite-rate fields that are broken by a matching field or an out-of-range field. A design that kept its count across such a break would flip the flag one or two fields early. It drives 54 Hz and 56 Hz trains, which catch a boundary put on the wrong side of 55 Hz. It also drives 44 Hz and 66 Hz trains and a long sync gap. A counter that wrapped instead of saturating would read that gap as a valid period and take a wrong decision. After a reset, the bench watches that the lone first edge yields no strobe. A design that classified it would report a spurious field.

// File: rtl/field_rate_pkg.sv
// Shared types for the field rate identifier.
// Assumes: nothing beyond the standard language.
package field_rate_pkg;
    typedef enum logic [1:0] {
        FR_NONE = 2'b00,  // out of range
        FR_50   = 2'b01,
        FR_60   = 2'b10
    } fr_class_e;
endpackage

// File: rtl/fr_sync_edge.sv
// Brings the asynchronous sync pulse into the clock domain and emits a
// one-cycle pulse on each rising edge.
// Assumes: the sync pulse stays high for at least two reference clocks.
module fr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // shift the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], async_i};
    end

    // remember the previous synchronized level and register the edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            edge_o <= 1'b0;
        end else begin
            last_q <= sync_q[STAGES-1];
            edge_o <= sync_q[STAGES-1] & ~last_q;
        end
    end

    // R9
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/fr_period_meter.sv
// Counts clocks between sync edges and classes each interval as 50 Hz,
// 60 Hz or out of range. The first edge after reset only arms the meter.
// Assumes: F_LO < F_MID < F_HI and CLK_HZ / F_HI > 1.
module fr_period_meter
    import field_rate_pkg::*;
#(
    parameter int CLK_HZ = 27_000_000,
    parameter int F_LO   = 45,
    parameter int F_MID  = 55,
    parameter int F_HI   = 65
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      edge_i,
    output logic      strobe_o,
    output fr_class_e cls_o
);
    localparam int LIM_LO  = CLK_HZ / F_LO;   // longest valid period
    localparam int LIM_MID = CLK_HZ / F_MID;  // longest 60 Hz period
    localparam int LIM_HI  = CLK_HZ / F_HI;   // shortest valid period
    localparam int SAT     = LIM_LO + 1;
    localparam int CW      = $clog2(SAT + 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;
    fr_class_e     cls_now;

    // sort the finished interval into a class
    always_comb begin
        if (cnt_q < CW'(LIM_HI) || cnt_q > CW'(LIM_LO)) cls_now = FR_NONE;
        else if (cnt_q > CW'(LIM_MID))                  cls_now = FR_50;
        else                                            cls_now = FR_60;
    end

    // period counter: restart on an edge, saturate past the slow limit
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= CW'(1);
        else if (edge_i)           cnt_q <= CW'(1);
        else if (cnt_q != CW'(SAT)) cnt_q <= cnt_q + CW'(1);
    end

    // arm on the first edge, then strobe the class on every later edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            strobe_o <= 1'b0;
            cls_o    <= FR_NONE;
        end else begin
            strobe_o <= edge_i & armed_q;
            if (edge_i) begin
                armed_q <= 1'b1;
                cls_o   <= cls_now;
            end
        end
    end

    // R7
    first_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !armed_q) |=> !strobe_o);
    // R8
    count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(SAT));
endmodule

// File: rtl/fr_decider.sv
// Holds the 50/60 decision. It flips only after CONFIRM consecutive fields
// of the opposite rate. Out-of-range or matching fields clear the run.
// Assumes: CONFIRM >= 1.
module fr_decider
    import field_rate_pkg::*;
#(
    parameter int CONFIRM = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strobe_i,
    input  fr_class_e cls_i,
    output logic      rate_60_o
);
    localparam int MW = $clog2(CONFIRM + 1);

    logic [MW-1:0] match_q;
    logic          opposite;

    // a field argues for a change when it is valid and differs from the flag
    always_comb begin
        opposite = (cls_i == FR_60 && !rate_60_o) || (cls_i == FR_50 && rate_60_o);
    end

    // run counter and decision flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q   <= '0;
            rate_60_o <= 1'b0;
        end else if (strobe_i) begin
            if (!opposite) begin
                match_q <= '0;
            end else if (match_q == MW'(CONFIRM - 1)) begin
                match_q   <= '0;
                rate_60_o <= ~rate_60_o;
            end else begin
                match_q <= match_q + MW'(1);
            end
        end
    end

    // R6
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!rate_60_o && match_q == '0));
    // R3
    out_of_range_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && cls_i == FR_NONE) |=> (match_q == '0 && $stable(rate_60_o)));
    // R4
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_q < MW'(CONFIRM));
    // R1
    flip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_60_o) |-> ($past(strobe_i) &&
            $past(cls_i) == (rate_60_o ? FR_60 : FR_50)));
endmodule

// File: rtl/field_rate_ident.sv
// Top: 50/60 Hz field rate identifier. It chains the synchronizer and edge
// detector, the period meter and the decision logic.
// Assumes: vsync_i is a clean pulse train; CLK_HZ is the clk frequency.
module field_rate_ident
    import field_rate_pkg::*;
#(
    parameter int CLK_HZ  = 27_000_000,
    parameter int F_LO    = 45,
    parameter int F_MID   = 55,
    parameter int F_HI    = 65,
    parameter int CONFIRM = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsync_i,
    output logic       rate_60_o,
    output logic       field_valid_o,
    output logic [1:0] field_class_o
);
    logic      vs_edge;
    fr_class_e cls;

    fr_sync_edge #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(vsync_i), .edge_o(vs_edge)
    );

    fr_period_meter #(
        .CLK_HZ(CLK_HZ), .F_LO(F_LO), .F_MID(F_MID), .F_HI(F_HI)
    ) u_meter (
        .clk(clk), .rst_n(rst_n), .edge_i(vs_edge),
        .strobe_o(field_valid_o), .cls_o(cls)
    );

    fr_decider #(.CONFIRM(CONFIRM)) u_dec (
        .clk(clk), .rst_n(rst_n), .strobe_i(field_valid_o),
        .cls_i(cls), .rate_60_o(rate_60_o)
    );

    assign field_class_o = cls;
endmodule

// File: tb/field_rate_ident_test.sv
// Bench for field_rate_ident with a scaled reference clock (CLK_HZ = 50000).
// At that rate a 50 Hz field is 1000 cycles and a 60 Hz field is 833 cycles.
module field_rate_ident_test;
    localparam int CLK_HZ = 50_000;
    localparam int NV     = 12;
    // vector table: field period in clocks, number of fields, expected flag
    localparam int VP [NV] = '{833, 833, 1000, 833, 1000, 1136, 1000, 757, 925, 892, 1000, 757};
    localparam int VN [NV] = '{2,   1,   2,    1,   2,    1,    2,    3,   3,   3,   3,    1};
    localparam int VE [NV] = '{0,   1,   1,    1,   1,    1,    1,    1,   0,   1,   0,    0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync = 1'b0;
    logic       rate_60;
    logic       fvalid;
    logic [1:0] fclass;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int last_edge = 0;
    int nstrobe = 0;
    int last_cls = 0;
    bit done = 1'b0;

    field_rate_ident #(.CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync),
        .rate_60_o(rate_60), .field_valid_o(fvalid), .field_class_o(fclass)
    );

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // record strobes away from the active edge
    always @(negedge clk) begin
        if (fvalid) begin
            nstrobe  = nstrobe + 1;
            last_cls = int'(fclass);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // emit n rising edges, each period clocks after the previous one
    task automatic fields(input int period, input int n);
        for (int i = 0; i < n; i++) begin
            while (cyc < last_edge + period) @(negedge clk);
            vsync = 1'b1;
            last_edge = cyc;
            repeat (4) @(negedge clk);
            vsync = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        vsync = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        chk("R6 flag after reset", int'(rate_60), 0);
        last_edge = cyc;
        fields(1000, 1);  // arming edge
        chk("R7 no strobe on first edge", nstrobe, 0);

        // table walk; tags R1 R2 R3 R4 R5 R10 per row order
        for (int v = 0; v < NV; v++) begin
            fields(VP[v], VN[v]);
            chk($sformatf("R1/R2/R3/R4/R5/R10 vector %0d", v), int'(rate_60), VE[v]);
        end

        // R8: a long gap, then a late edge, breaks a run of two
        fields(833, 2);
        fields(3000, 1);
        chk("R8 late edge class", last_cls, 0);
        fields(833, 1);
        chk("R8 flag holds after gap", int'(rate_60), 0);
        fields(833, 2);
        chk("R1 flips after three clean fields", int'(rate_60), 1);

        // R6 reset from the high state, R7 and R9 afterwards
        do_reset();
        chk("R6 reset clears high flag", int'(rate_60), 0);
        nstrobe = 0;
        last_edge = cyc;
        fields(900, 1);
        chk("R7 first edge silent", nstrobe, 0);
        fields(833, 1);
        chk("R9 one strobe per field", nstrobe, 1);
        chk("R9 class 60 code", last_cls, 2);
        fields(1000, 1);
        chk("R9 class 50 code", last_cls, 1);
        fields(909, 1);
        chk("R5 exact 55 Hz edge is 60", last_cls, 2);
        fields(1136, 1);
        chk("R9 class none code", last_cls, 0);
        chk("R2 flag low", int'(rate_60), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (190_000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule